// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small, fully associative set of recently used virtual-page to physical-frame translations. Each stored translation carries a process tag, so several address spaces can live in the cache at once and a context switch does not force a flush. A lookup compares the request against every valid entry in the same cycle. The result is reported combinationally in three ways: a hit with the frame number and permission bits, a permission fault, or a miss.

After a miss, an external page-table walker supplies the translation through the fill port. The fill is visible to lookups from the next cycle on. The fill uses a free entry when one exists. When the cache is full, a parameter selects the victim policy: exact least-recently-used ordering, or a pseudo-random index from a free-running shift register. Software can drop every entry of one address space, or every entry, with a single-cycle command.

Top module: `asid_tlb`

## Requirements
- R1: After synchronous active-low reset, all entries are invalid and every lookup reports a miss.
- R2: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high in the same cycle. While `lk_valid` is low, all three are low.
- R3: A lookup hits only when one valid entry matches both the page number and the address-space tag. It then returns that entry's frame number and permission bits on `lk_pfn` and `lk_perm`.
- R4: Permission bits are bit0 = read, bit1 = write, bit2 = execute. `lk_kind` 2'b00 requests a read, 2'b01 a write, and 2'b10 or 2'b11 an execute. A matching entry whose bit for the requested kind is clear raises `lk_fault`, not `lk_hit`. `lk_pfn` and `lk_perm` still show the entry.
- R5: A fill is visible to lookups from the next cycle on. When any entry is invalid, the fill goes to the lowest-index invalid entry and evicts nothing.
- R6: A fill whose page number and tag match an existing valid entry overwrites that entry, so no duplicate is created.
- R7: With `USE_RANDOM`=0 and all entries valid, a fill replaces the entry that has gone longest without being hit or filled.
- R8: With `USE_RANDOM`=1 and all entries valid, a fill replaces exactly one existing entry, chosen by a free-running 16-bit LFSR. The new translation hits afterwards.
- R9: `flush_asid_en` invalidates, in one cycle, every entry whose tag equals `flush_asid`. Entries with other tags are kept.
- R10: `flush_all` invalidates every entry in one cycle.
- R11: `flush_all` takes precedence over `flush_asid_en`, and either flush takes precedence over a fill. A fill in a flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 1x execute |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No matching valid entry |
| lk_fault | output | 1 | Entry found but access kind not permitted |
| lk_pfn | output | PFN_W | Frame number of the matching entry, zero otherwise |
| lk_perm | output | 3 | Permission bits of the matching entry, zero otherwise |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_asid | input | ASID_W | Address-space tag of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_perm | input | 3 | Permission bits of the fill |
| flush_asid_en | input | 1 | Invalidate all entries carrying `flush_asid` |
| flush_asid | input | ASID_W | Tag selected for invalidation |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The bench targets several corner cases, each tied to a specific design error:
- Same page, different tag: a design that ignores the tag returns another process's frame.
- Refill of an existing page: a design that allocates a duplicate ORs two frame numbers together on the next hit.
- Fill into a partly flushed cache: a design that consults the victim policy before free slots evicts live translations of a surviving process.
- Recently hit entry in a full cache: a design that tracks only fill order evicts the entry that was just used.
- Fills issued in the same cycle as either flush: a design with the wrong precedence leaves a translation behind that should be gone.

// File: rtl/tlb_pkg.sv
// Package: shared encodings for the address-space-tagged translation cache.
// Assumes permission vectors are three bits wide in read/write/execute order.
package tlb_pkg;

    localparam int PERM_W  = 3;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_EXEC2 = 2'b11
    } acc_kind_e;

    // Returns the permission bit an access kind requires.
    function automatic logic perm_allows(logic [PERM_W-1:0] perm, logic [1:0] kind);
        case (kind)
            ACC_READ:  return perm[PERM_RD];
            ACC_WRITE: return perm[PERM_WR];
            default:   return perm[PERM_EX];
        endcase
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
// Module: entry storage with two parallel compare ports.
// One port serves lookups and one serves fills. The fill port detects an
// existing entry for the same page and tag.
// Assumes the caller never raises wr_en in a cycle where a clear is active.
module tlb_entry_array #(
    parameter int N      = 32,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 16,
    localparam int IDX_W = $clog2(N),
    localparam int PW    = tlb_pkg::PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N-1:0]      lk_match,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PW-1:0]     lk_perm,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    output logic [N-1:0]      fl_match,
    output logic [N-1:0]      valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PW-1:0]     wr_perm,
    input  logic              clr_all,
    input  logic              clr_asid_en,
    input  logic [ASID_W-1:0] clr_asid
);

    logic [N-1:0][VPN_W-1:0]  vpn_q;
    logic [N-1:0][ASID_W-1:0] asid_q;
    logic [N-1:0][PFN_W-1:0]  pfn_q;
    logic [N-1:0][PW-1:0]     perm_q;
    logic [N-1:0]             valid_q;

    for (genvar i = 0; i < N; i++) begin : g_entry
        // Valid bit: cleared by either flush, set by a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[i] <= 1'b0;
            else if (clr_all || (clr_asid_en && asid_q[i] == clr_asid))
                valid_q[i] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(i))
                valid_q[i] <= 1'b1;
        end

        // Payload: captured on a write to this slot, no reset needed.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                vpn_q[i]  <= fl_vpn;
                asid_q[i] <= fl_asid;
                pfn_q[i]  <= wr_pfn;
                perm_q[i] <= wr_perm;
            end
        end

        // Parallel tag compares for both ports.
        assign lk_match[i] = valid_q[i] && vpn_q[i] == lk_vpn && asid_q[i] == lk_asid;
        assign fl_match[i] = valid_q[i] && vpn_q[i] == fl_vpn && asid_q[i] == fl_asid;
    end

    // Read-out: OR of the payloads of matching entries (at most one by construction of fills).
    always_comb begin
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                lk_pfn  = lk_pfn | pfn_q[i];
                lk_perm = lk_perm | perm_q[i];
            end
        end
    end

    assign valid = valid_q;

endmodule

// File: rtl/tlb_repl.sv
// Module: victim selection for a full cache.
// USE_RANDOM=0 keeps an exact recency rank per entry (0 = most recent). A hit
// and then a fill in the same cycle are applied in that order.
// USE_RANDOM=1 uses a free-running 16-bit LFSR. It assumes N is a power of two
// no larger than 2**16.
module tlb_repl #(
    parameter int N          = 32,
    parameter bit USE_RANDOM = 1'b0,
    localparam int IDX_W     = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [IDX_W-1:0] victim
);

    typedef logic [N-1:0][IDX_W-1:0] rank_t;

    // Moves entry k to rank 0 and ages every entry that was more recent than it.
    function automatic rank_t promote(rank_t r, logic [IDX_W-1:0] k);
        rank_t o = r;
        for (int i = 0; i < N; i++)
            if (r[i] < r[k]) o[i] = r[i] + 1'b1;
        o[k] = '0;
        return o;
    endfunction

    if (!USE_RANDOM) begin : g_lru
        rank_t rank_q, rank_h, rank_n;

        // Next ranks: apply the hit, then the fill.
        always_comb begin
            rank_h = hit_en  ? promote(rank_q, hit_idx)  : rank_q;
            rank_n = fill_en ? promote(rank_h, fill_idx) : rank_h;
        end

        // Rank register: reset to a valid permutation.
        always_ff @(posedge clk) begin
            if (!rst_n)
                for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
            else
                rank_q <= rank_n;
        end

        // Victim is the entry holding the oldest rank.
        always_comb begin
            victim = '0;
            for (int i = 0; i < N; i++)
                if (rank_q[i] == IDX_W'(N - 1)) victim = IDX_W'(i);
        end
    end else begin : g_rnd
        logic [15:0] lfsr_q;

        // Free-running maximal-length shift register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lfsr_q <= 16'hACE1;
            else
                lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        end

        assign victim = lfsr_q[IDX_W-1:0];
    end

endmodule

// File: rtl/asid_tlb.sv
// Module: top of the address-space-tagged translation cache.
// It classifies lookups into hit, miss or fault, and places fills in this
// order: existing entry, free entry, policy victim. Flushes override fills.
// Assumes ENTRIES is a power of two when USE_RANDOM is set.
module asid_tlb #(
    parameter int ENTRIES    = 32,
    parameter int VPN_W      = 20,
    parameter int ASID_W     = 8,
    parameter int PFN_W      = 16,
    parameter bit USE_RANDOM = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_kind,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [2:0]        lk_perm,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [2:0]        fill_perm,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              flush_all
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] lk_match, fl_match, valid;
    logic [IDX_W-1:0]   hit_idx, dup_idx, free_idx, victim, wr_idx;
    logic               any_match, permitted, has_free, do_fill;

    tlb_entry_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_vpn      (lk_vpn),
        .lk_asid     (lk_asid),
        .lk_match    (lk_match),
        .lk_pfn      (lk_pfn),
        .lk_perm     (lk_perm),
        .fl_vpn      (fill_vpn),
        .fl_asid     (fill_asid),
        .fl_match    (fl_match),
        .valid       (valid),
        .wr_en       (do_fill),
        .wr_idx      (wr_idx),
        .wr_pfn      (fill_pfn),
        .wr_perm     (fill_perm),
        .clr_all     (flush_all),
        .clr_asid_en (flush_asid_en && !flush_all),
        .clr_asid    (flush_asid)
    );

    tlb_repl #(.N(ENTRIES), .USE_RANDOM(USE_RANDOM)) u_repl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_en   (lk_hit),
        .hit_idx  (hit_idx),
        .fill_en  (do_fill),
        .fill_idx (wr_idx),
        .victim   (victim)
    );

    // Encoders: index of the lookup match, of the fill match and of the lowest free slot.
    always_comb begin
        hit_idx  = '0;
        dup_idx  = '0;
        free_idx = '0;
        has_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) hit_idx = IDX_W'(i);
            if (fl_match[i]) dup_idx = IDX_W'(i);
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    // Lookup classification.
    always_comb begin
        any_match = |lk_match;
        permitted = tlb_pkg::perm_allows(lk_perm, lk_kind);
        lk_hit    = lk_valid && any_match && permitted;
        lk_fault  = lk_valid && any_match && !permitted;
        lk_miss   = lk_valid && !any_match;
    end

    // Fill placement: overwrite a duplicate, else a free slot, else the victim.
    always_comb begin
        do_fill = fill_valid && !flush_all && !flush_asid_en;
        if (|fl_match)     wr_idx = dup_idx;
        else if (has_free) wr_idx = free_idx;
        else               wr_idx = victim;
    end

endmodule

// File: rtl/tlb_checker.sv
// Module: temporal checks on the port behaviour of asid_tlb, bound below.
// Assumes nothing about the internals; it observes ports only.
module tlb_checker #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic [PFN_W-1:0]  lk_pfn,
    input logic [2:0]        lk_perm,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic [PFN_W-1:0]  fill_pfn,
    input logic [2:0]        fill_perm,
    input logic              flush_asid_en,
    input logic [ASID_W-1:0] flush_asid,
    input logic              flush_all
);

    logic past_ok;

    // Marks cycles that have a post-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!past_ok && lk_valid) |-> lk_miss);

    a_r2_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lk_valid && $past(fill_valid && !flush_all && !flush_asid_en)
         && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid))
        |-> ((lk_hit || lk_fault) && lk_pfn == $past(fill_pfn) && lk_perm == $past(fill_perm)));

    a_r9_asid_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lk_valid && $past(flush_asid_en) && lk_asid == $past(flush_asid)) |-> lk_miss);

    a_r10_all_gone: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !(lk_hit || lk_fault));

endmodule

bind asid_tlb tlb_checker #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_checker (.*);

// File: tb/asid_tlb_test.sv
// Bench: a vector table first, then directed reset, precedence, placement and replacement tests.
module asid_tlb_test;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_valid, fill_valid, flush_asid_en, flush_all;
    logic [19:0] lk_vpn, fill_vpn;
    logic [7:0]  lk_asid, fill_asid, flush_asid;
    logic [1:0]  lk_kind;
    logic [15:0] fill_pfn;
    logic [2:0]  fill_perm;
    logic        hit, miss, fault, r_hit, r_miss, r_fault;
    logic [15:0] pfn, r_pfn;
    logic [2:0]  perm, r_perm;
    int          n_checks = 0, n_fail = 0;

    always #10 clk = ~clk;

    asid_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_kind(lk_kind), .lk_hit(hit), .lk_miss(miss), .lk_fault(fault), .lk_pfn(pfn),
        .lk_perm(perm), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush_asid_en(flush_asid_en),
        .flush_asid(flush_asid), .flush_all(flush_all));

    asid_tlb #(.USE_RANDOM(1'b1)) uut_rnd (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_kind(lk_kind), .lk_hit(r_hit), .lk_miss(r_miss), .lk_fault(r_fault), .lk_pfn(r_pfn),
        .lk_perm(r_perm), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush_asid_en(flush_asid_en),
        .flush_asid(flush_asid), .flush_all(flush_all));

    // op: 0 fill, 1 lookup, 2 flush tag, 3 flush all; res: 0 miss, 1 hit, 2 fault
    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic [1:0]  kind;
        logic [15:0] pfn;
        logic [2:0]  perm;
        logic [1:0]  res;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 20'h10, 8'd1, 2'd0, 16'h0,   3'b000, 2'd0, 4'd1},  // R1 empty
        '{2'd0, 20'h10, 8'd1, 2'd0, 16'hA0,  3'b011, 2'd3, 4'd5},
        '{2'd1, 20'h10, 8'd1, 2'd0, 16'hA0,  3'b011, 2'd1, 4'd5},  // R5 R3
        '{2'd1, 20'h10, 8'd2, 2'd0, 16'h0,   3'b000, 2'd0, 4'd3},  // R3 other tag
        '{2'd1, 20'h11, 8'd1, 2'd0, 16'h0,   3'b000, 2'd0, 4'd3},  // R3 other page
        '{2'd1, 20'h10, 8'd1, 2'd1, 16'hA0,  3'b011, 2'd1, 4'd4},  // R4 write ok
        '{2'd1, 20'h10, 8'd1, 2'd2, 16'hA0,  3'b011, 2'd2, 4'd4},  // R4 exec fault
        '{2'd0, 20'h20, 8'd2, 2'd0, 16'hB0,  3'b101, 2'd3, 4'd5},
        '{2'd1, 20'h20, 8'd2, 2'd1, 16'hB0,  3'b101, 2'd2, 4'd4},  // R4 write fault
        '{2'd1, 20'h20, 8'd2, 2'd3, 16'hB0,  3'b101, 2'd1, 4'd4},  // R4 exec alt code
        '{2'd0, 20'h10, 8'd1, 2'd0, 16'hC0,  3'b111, 2'd3, 4'd6},
        '{2'd1, 20'h10, 8'd1, 2'd2, 16'hC0,  3'b111, 2'd1, 4'd6},  // R6 overwrite
        '{2'd0, 20'h30, 8'd1, 2'd0, 16'hD0,  3'b001, 2'd3, 4'd5},
        '{2'd2, 20'h0,  8'd1, 2'd0, 16'h0,   3'b000, 2'd3, 4'd9},
        '{2'd1, 20'h10, 8'd1, 2'd0, 16'h0,   3'b000, 2'd0, 4'd9},  // R9 gone
        '{2'd1, 20'h30, 8'd1, 2'd0, 16'h0,   3'b000, 2'd0, 4'd9},  // R9 gone
        '{2'd1, 20'h20, 8'd2, 2'd0, 16'hB0,  3'b101, 2'd1, 4'd9},  // R9 kept
        '{2'd3, 20'h0,  8'd0, 2'd0, 16'h0,   3'b000, 2'd3, 4'd10},
        '{2'd1, 20'h20, 8'd2, 2'd0, 16'h0,   3'b000, 2'd0, 4'd10}  // R10 gone
    };

    // Records one check; prints a FAIL line with actual and expected on mismatch.
    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Brings every input to its idle value.
    task automatic idle();
        lk_valid = 0; fill_valid = 0; flush_asid_en = 0; flush_all = 0;
        lk_vpn = '0; lk_asid = '0; lk_kind = '0;
        fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0; flush_asid = '0;
    endtask

    // Drives a fill after the falling edge; it commits at the next rising edge.
    task automatic do_fill(input logic [19:0] v, input logic [7:0] a, input logic [15:0] p, input logic [2:0] pm);
        @(negedge clk); idle();
        fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = pm;
    endtask

    // Drives a lookup after the falling edge and samples the combinational result 2 ns later.
    task automatic do_look(input logic [19:0] v, input logic [7:0] a, input logic [1:0] k);
        @(negedge clk); idle();
        lk_valid = 1; lk_vpn = v; lk_asid = a; lk_kind = k;
        #2;
    endtask

    task automatic do_flush(input logic all, input logic [7:0] a);
        @(negedge clk); idle();
        if (all) flush_all = 1; else begin flush_asid_en = 1; flush_asid = a; end
    endtask

    // Returns the lookup result code: 0 miss, 1 hit, 2 fault, 3 inconsistent.
    function automatic logic [1:0] res_code();
        if (hit && !miss && !fault) return 2'd1;
        if (miss && !hit && !fault) return 2'd0;
        if (fault && !hit && !miss) return 2'd2;
        return 2'd3;
    endfunction

    initial begin : watchdog
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int evicted;
        idle();
        repeat (3) @(posedge clk);
        // R1: idle outputs during reset
        #2 check(!hit && !miss && !fault, "R1", {hit, miss, fault}, 0);
        @(negedge clk); rst_n = 1;

        // Vector table walk
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            case (v.op)
                2'd0: do_fill(v.vpn, v.asid, v.pfn, v.perm);
                2'd2: do_flush(1'b0, v.asid);
                2'd3: do_flush(1'b1, 8'd0);
                default: begin
                    do_look(v.vpn, v.asid, v.kind);
                    check(res_code() == v.res, $sformatf("R%0d vec %0d result", v.req, i), res_code(), v.res);
                    if (v.res != 2'd0)
                        check(pfn == v.pfn && perm == v.perm, $sformatf("R%0d vec %0d pfn/perm", v.req, i),
                              {pfn, perm}, {v.pfn, v.perm});
                end
            endcase
        end

        // R2: idle cycle raises nothing
        @(negedge clk); idle(); #2;
        check(!hit && !miss && !fault, "R2 idle", {hit, miss, fault}, 0);

        // R11: fills in flush cycles are dropped
        do_flush(1'b0, 8'd7); fill_valid = 1; fill_vpn = 20'h40; fill_asid = 8'd3; fill_pfn = 16'h40; fill_perm = 3'b001;
        do_look(20'h40, 8'd3, 2'd0);
        check(miss, "R11 fill under tag flush", res_code(), 0);
        do_flush(1'b1, 8'd0); fill_valid = 1; fill_vpn = 20'h41; fill_asid = 8'd3; fill_pfn = 16'h41; fill_perm = 3'b001;
        do_look(20'h41, 8'd3, 2'd0);
        check(miss, "R11 fill under full flush", res_code(), 0);
        do_fill(20'h42, 8'd3, 16'h42, 3'b001);
        do_flush(1'b1, 8'd0); flush_asid_en = 1; flush_asid = 8'd9;
        do_look(20'h42, 8'd3, 2'd0);
        check(miss, "R11 full flush wins", res_code(), 0);

        // R7 / R8: fill all entries, hit the oldest, then force one replacement
        for (int i = 0; i < 32; i++) do_fill(20'h100 + i, 8'd4, 16'h100 + i, 3'b001);
        do_look(20'h100, 8'd4, 2'd0);
        check(hit, "R7 oldest hits", res_code(), 1);
        do_fill(20'h200, 8'd4, 16'h200, 3'b001);
        do_look(20'h101, 8'd4, 2'd0);
        check(miss, "R7 least recent evicted", res_code(), 0);
        do_look(20'h100, 8'd4, 2'd0);
        check(hit, "R7 recently hit kept", res_code(), 1);
        do_look(20'h200, 8'd4, 2'd0);
        check(hit && pfn == 16'h200, "R7 new entry", pfn, 16'h200);
        check(r_hit && r_pfn == 16'h200, "R8 new entry random", r_pfn, 16'h200);
        evicted = 0;
        for (int i = 0; i < 32; i++) begin
            do_look(20'h100 + i, 8'd4, 2'd0);
            if (r_miss) evicted++;
        end
        check(evicted == 1, "R8 exactly one evicted", evicted, 1);

        // R5: after a tag flush, fills use free slots and evict nothing
        do_flush(1'b1, 8'd0);
        for (int i = 0; i < 32; i++) do_fill(20'h300 + i, (i % 2 == 0) ? 8'd5 : 8'd6, 16'h300 + i, 3'b001);
        do_flush(1'b0, 8'd5);
        for (int j = 0; j < 16; j++) do_fill(20'h400 + j, 8'd7, 16'h400 + j, 3'b001);
        for (int i = 1; i < 32; i += 2) begin
            do_look(20'h300 + i, 8'd6, 2'd0);
            check(hit && pfn == 16'(20'h300 + i), "R5 survivor kept", pfn, 16'(20'h300 + i));
        end
        for (int j = 0; j < 16; j++) begin
            do_look(20'h400 + j, 8'd7, 2'd0);
            check(hit, "R5 free-slot fill", res_code(), 1);
        end

        // R1: reset in mid-run clears everything
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); rst_n = 1;
        do_look(20'h301, 8'd6, 2'd0);
        check(miss, "R1 reset clears", res_code(), 0);

        @(negedge clk); idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule